// File: doc/BRIEF.md
# Barrel Shifter Operand Generator

This combinational unit forms the second operand of a data-processing instruction, together with the shifter carry-out, for a 32-bit load/store processor. It takes the instruction word, the values already read for the shifted register and the amount register, and the current carry flag. It produces the shifted or rotated operand and the carry the ALU would latch for flag-setting logical operations. Register-file reads, the ALU itself and flag write-back stay outside the unit.

Two operand forms are supported. The first is a shifted register, whose amount comes either from a 5-bit immediate field or from the low byte of a second register. The second is an 8-bit constant rotated right by an even amount. The unit applies the processor's exact corner-case rules: a zero immediate amount stands for a shift by 32 or for a rotate-with-extend, and register amounts of 32 or more have special results. It also raises a flag when a register-specified shift costs one extra cycle. When either register index names the program counter in a register-specified shift, the unit adds the pipeline offset to the value it was given.

Top module: `barrel_operand_gen`

## Requirements
- R1: With `use_imm` low, bit 4 of `instr` selects a register amount (low 8 bits of `rs_val`; upper bits of `rs_val` are ignored) over an immediate amount in bits 11:7. Bits 6:5 pick the mode: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right. Bits 3:0 index the shifted register and bits 11:8 index the amount register.
- R2: A register amount of zero outputs `rm_val` unchanged with `carry_out` equal to `carry_in`. An immediate left shift of zero does the same.
- R3: A left logical shift by a register amount of exactly 32 gives 0 with carry equal to bit 0 of the source. Any larger amount gives 0 with carry 0.
- R4: A right logical shift by a register amount of 32 gives 0 with carry equal to source bit 31, and a larger amount gives 0 with carry 0. An immediate amount of zero acts as a shift by 32.
- R5: A right arithmetic shift by 32 or more (register amount, or an immediate amount of zero) gives every bit equal to source bit 31, with carry equal to source bit 31.
- R6: An immediate rotate of zero is a rotate-with-extend: the result is `carry_in` in bit 31 above source bits 31:1, and the carry is source bit 0. A register rotate whose 8-bit amount is nonzero with low 5 bits zero returns the source unchanged, with carry equal to source bit 31.
- R7: For an effective amount n from 1 to 31, the carry is the last bit shifted out: source bit 32-n for a left shift, and bit n-1 for right shifts and rotates. A register rotate uses the amount modulo 32.
- R8: With `use_imm` high, `instr[7:0]` is rotated right by twice `instr[11:8]`. A zero rotation keeps `carry_in`; otherwise the carry is bit 31 of the result.
- R9: `extra_cycle` is high exactly when `use_imm` is low and `instr[4]` is high.
- R10: In a register-specified shift, a register index of 15 (in bits 3:0 or 11:8) makes the unit use the given value plus 4. Immediate-amount shifts use `rm_val` as given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word (fields in bits 11:0) |
| use_imm | input | 1 | Selects the rotated 8-bit constant form |
| rm_val | input | 32 | Value read for the shifted register |
| rs_val | input | 32 | Value read for the amount register |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Shifter result |
| carry_out | output | 1 | Shifter carry-out |
| extra_cycle | output | 1 | Register-specified shift needs one more cycle |

## Verification
The bench aims at the amount boundaries 0, 32, 33 and large register bytes, where a design that clamped the amount to five bits would wrap a shift by 32 into a no-op and return the source instead of zero. It checks the zero-immediate encodings, where a design that treated zero literally would pass the source through for right shifts and miss the rotate-with-extend. It checks register rotates by multiples of 32, which must report bit 31 rather than the incoming carry. It checks the rotated constant, whose carry must follow the result only when the rotation is nonzero. It also checks the program-counter offset, which must apply only in the register-amount form and be missing or misapplied nowhere else.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  localparam int DATA_W  = 32;
  localparam int AMT_W   = 8;
  localparam int IDX_W   = 4;
  localparam int SHIFT_W = $clog2(DATA_W);

  typedef enum logic [2:0] {
    K_LSL, K_LSR, K_ASR, K_ROR, K_RRX
  } sh_kind_t;

  function automatic logic [DATA_W-1:0] rotr(input logic [DATA_W-1:0] x,
                                             input logic [SHIFT_W-1:0] r);
    return (x >> r) | (x << (SHIFT_W'(DATA_W - int'(r))));
  endfunction
endpackage

// File: rtl/bsh_amount_decode.sv
module bsh_amount_decode
  import bsh_pkg::*;
#(
  parameter int PC_IDX   = 15,
  parameter int PC_AHEAD = 4
) (
  input  logic [DATA_W-1:0] instr,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [DATA_W-1:0] rs_val,
  output sh_kind_t          kind,
  output logic [AMT_W-1:0]  amount,
  output logic [DATA_W-1:0] src,
  output logic              reg_shift
);
  logic [DATA_W-1:0] rs_eff;
  logic [4:0]        imm5;
  logic [1:0]        mode;

  assign reg_shift = ~use_imm & instr[4];
  assign imm5      = instr[11:7];
  assign mode      = instr[6:5];

  assign src    = rm_val + ((reg_shift && instr[3:0] == IDX_W'(PC_IDX)) ? DATA_W'(PC_AHEAD) : '0);
  assign rs_eff = rs_val + ((reg_shift && instr[11:8] == IDX_W'(PC_IDX)) ? DATA_W'(PC_AHEAD) : '0);

  always_comb begin
    amount = reg_shift ? rs_eff[AMT_W-1:0] : AMT_W'(imm5);
    case (mode)
      2'b00:   kind = K_LSL;
      2'b01:   kind = K_LSR;
      2'b10:   kind = K_ASR;
      default: kind = K_ROR;
    endcase
    if (!reg_shift && imm5 == 5'd0) begin
      case (mode)
        2'b01, 2'b10: amount = AMT_W'(DATA_W);
        2'b11:        kind   = K_RRX;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/bsh_shift_core.sv
module bsh_shift_core
  import bsh_pkg::*;
(
  input  sh_kind_t          kind,
  input  logic [AMT_W-1:0]  amount,
  input  logic [DATA_W-1:0] src,
  input  logic              carry_in,
  output logic [DATA_W-1:0] value,
  output logic              carry
);
  logic [SHIFT_W-1:0] n5;
  logic [SHIFT_W-1:0] left_idx;
  logic [SHIFT_W-1:0] right_idx;
  logic               is_zero;
  logic               is_full;
  logic               is_wide;

  assign n5        = amount[SHIFT_W-1:0];
  assign left_idx  = SHIFT_W'(0) - n5;
  assign right_idx = n5 - SHIFT_W'(1);
  assign is_zero   = (amount == '0);
  assign is_full   = (amount == AMT_W'(DATA_W));
  assign is_wide   = (amount > AMT_W'(DATA_W));

  always_comb begin
    value = src;
    carry = carry_in;
    case (kind)
      K_LSL: begin
        if (is_wide) begin value = '0; carry = 1'b0; end
        else if (is_full) begin value = '0; carry = src[0]; end
        else if (!is_zero) begin value = src << n5; carry = src[left_idx]; end
      end
      K_LSR: begin
        if (is_wide) begin value = '0; carry = 1'b0; end
        else if (is_full) begin value = '0; carry = src[DATA_W-1]; end
        else if (!is_zero) begin value = src >> n5; carry = src[right_idx]; end
      end
      K_ASR: begin
        if (is_wide || is_full) begin
          value = {DATA_W{src[DATA_W-1]}};
          carry = src[DATA_W-1];
        end else if (!is_zero) begin
          value = DATA_W'($signed(src) >>> n5);
          carry = src[right_idx];
        end
      end
      K_ROR: begin
        if (!is_zero) begin
          if (n5 == '0) carry = src[DATA_W-1];
          else begin value = rotr(src, n5); carry = src[right_idx]; end
        end
      end
      default: begin
        value = {carry_in, src[DATA_W-1:1]};
        carry = src[0];
      end
    endcase
  end
endmodule

// File: rtl/bsh_imm_rotate.sv
module bsh_imm_rotate
  import bsh_pkg::*;
(
  input  logic [11:0]       field,
  input  logic              carry_in,
  output logic [DATA_W-1:0] value,
  output logic              carry
);
  logic [SHIFT_W-1:0] rot;

  assign rot   = SHIFT_W'({field[11:8], 1'b0});
  assign value = rotr(DATA_W'(field[7:0]), rot);
  assign carry = (rot == '0) ? carry_in : value[DATA_W-1];
endmodule

// File: rtl/barrel_operand_gen.sv
module barrel_operand_gen
  import bsh_pkg::*;
#(
  parameter int PC_IDX   = 15,
  parameter int PC_AHEAD = 4
) (
  input  logic [31:0] instr,
  input  logic        use_imm,
  input  logic [31:0] rm_val,
  input  logic [31:0] rs_val,
  input  logic        carry_in,
  output logic [31:0] operand,
  output logic        carry_out,
  output logic        extra_cycle
);
  sh_kind_t          kind;
  logic [AMT_W-1:0]  amount;
  logic [DATA_W-1:0] src;
  logic              reg_shift;
  logic [DATA_W-1:0] sh_value;
  logic              sh_carry;
  logic [DATA_W-1:0] im_value;
  logic              im_carry;

  bsh_amount_decode #(.PC_IDX(PC_IDX), .PC_AHEAD(PC_AHEAD)) u_dec (
    .instr(instr), .use_imm(use_imm), .rm_val(rm_val), .rs_val(rs_val),
    .kind(kind), .amount(amount), .src(src), .reg_shift(reg_shift)
  );

  bsh_shift_core u_core (
    .kind(kind), .amount(amount), .src(src), .carry_in(carry_in),
    .value(sh_value), .carry(sh_carry)
  );

  bsh_imm_rotate u_rot (
    .field(instr[11:0]), .carry_in(carry_in), .value(im_value), .carry(im_carry)
  );

  assign operand     = use_imm ? im_value : sh_value;
  assign carry_out   = use_imm ? im_carry : sh_carry;
  assign extra_cycle = reg_shift;

  always_comb begin
    a_r9_extra_only_reg: assert (!(extra_cycle && use_imm))
      else $error("R9 extra cycle raised for constant form");
    if (reg_shift && amount == '0) begin
      a_r2_zero_passes: assert (operand == src && carry_out == carry_in)
        else $error("R2 zero register amount altered operand");
    end
    if (!use_imm && kind == K_RRX) begin
      a_r6_rrx_bits: assert (carry_out == rm_val[0] && operand[DATA_W-1] == carry_in)
        else $error("R6 rotate-with-extend mismatch");
    end
    if (!use_imm && kind == K_ASR && amount >= AMT_W'(DATA_W)) begin
      a_r5_asr_fill: assert (operand == {DATA_W{src[DATA_W-1]}} && carry_out == src[DATA_W-1])
        else $error("R5 arithmetic fill mismatch");
    end
    if (!use_imm && (kind == K_LSL || kind == K_LSR) && amount > AMT_W'(DATA_W)) begin
      a_r3_wide_zero: assert (operand == '0 && !carry_out)
        else $error("R3 wide logical shift not zero");
    end
    if (use_imm && instr[11:8] == 4'd0) begin
      a_r8_norot_keeps_carry: assert (carry_out == carry_in && operand == DATA_W'(instr[7:0]))
        else $error("R8 unrotated constant mismatch");
    end
  end
endmodule

// File: tb/sim_barrel_operand_gen.sv
module sim_barrel_operand_gen;
  logic        clk = 1'b0;
  logic [31:0] instr = '0;
  logic        use_imm = 1'b0;
  logic [31:0] rm_val = '0;
  logic [31:0] rs_val = '0;
  logic        carry_in = 1'b0;
  logic [31:0] operand;
  logic        carry_out;
  logic        extra_cycle;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  barrel_operand_gen u0 (
    .instr(instr), .use_imm(use_imm), .rm_val(rm_val), .rs_val(rs_val),
    .carry_in(carry_in), .operand(operand), .carry_out(carry_out),
    .extra_cycle(extra_cycle)
  );

  function automatic void model(input logic [31:0] ins, input logic [31:0] a_in,
                                input logic [31:0] b_in, input bit c, input bit imm,
                                output logic [31:0] v, output bit co, output bit xc);
    logic [31:0] a = a_in;
    logic [31:0] b = b_in;
    logic [63:0] w;
    int n;
    int k;
    xc = !imm && ins[4];
    if (imm) begin
      k = 2 * int'(ins[11:8]);
      v = {24'b0, ins[7:0]};
      for (int i = 0; i < k; i++) v = {v[0], v[31:1]};
      co = (k == 0) ? c : v[31];
      return;
    end
    if (xc) begin
      if (ins[3:0] == 4'd15) a = a + 32'd4;
      if (ins[11:8] == 4'd15) b = b + 32'd4;
      n = int'(b[7:0]);
    end else begin
      n = int'(ins[11:7]);
      if (n == 0) begin
        if (ins[6:5] == 2'b01 || ins[6:5] == 2'b10) n = 32;
        if (ins[6:5] == 2'b11) begin
          v = {c, a[31:1]}; co = a[0]; return;
        end
      end
    end
    if (n == 0) begin v = a; co = c; return; end
    case (ins[6:5])
      2'b00: if (n > 32) begin v = 0; co = 0; end
             else begin w = {32'b0, a} << n; v = w[31:0]; co = w[32]; end
      2'b01: if (n > 32) begin v = 0; co = 0; end
             else begin w = {a, 32'b0} >> n; v = w[63:32]; co = w[31]; end
      2'b10: begin
        if (n > 32) n = 32;
        w = {a, 32'b0};
        for (int i = 0; i < n; i++) w = {w[63], w[63:1]};
        v = w[63:32]; co = w[31];
      end
      default: begin
        v = a;
        for (int i = 0; i < n; i++) v = {v[0], v[31:1]};
        co = v[31];
      end
    endcase
  endfunction

  task automatic apply(input string req, input logic [31:0] ins, input bit imm,
                       input logic [31:0] a, input logic [31:0] b, input bit c);
    logic [31:0] ev;
    bit ec;
    bit ex;
    @(posedge clk);
    #1;
    instr = ins; use_imm = imm; rm_val = a; rs_val = b; carry_in = c;
    model(ins, a, b, c, imm, ev, ec, ex);
    @(negedge clk);
    checks++;
    if (operand !== ev || carry_out !== ec || extra_cycle !== ex) begin
      errors++;
      $display("FAIL %s: actual op=%h c=%b x=%b expected op=%h c=%b x=%b (instr=%h)",
               req, operand, carry_out, extra_cycle, ev, ec, ex, ins);
    end
  endtask

  function automatic logic [31:0] rsh(input logic [1:0] m, input logic [3:0] rs, input logic [3:0] rm);
    return {20'b0, rs, 1'b0, m, 1'b1, rm};
  endfunction
  function automatic logic [31:0] ish(input logic [1:0] m, input logic [4:0] a, input logic [3:0] rm);
    return {20'b0, a, m, 1'b0, rm};
  endfunction
  function automatic logic [31:0] cst(input logic [3:0] r, input logic [7:0] v);
    return {20'b0, r, v};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    apply("R1 idle", 32'h0, 1'b0, 32'h0, 32'h0, 1'b0);
    apply("R1 rs upper bits ignored", rsh(2'b00, 4'd2, 4'd1), 1'b0, 32'h0000_00F1, 32'hFFFF_FF04, 1'b0);
    apply("R2 reg zero amount", rsh(2'b01, 4'd2, 4'd1), 1'b0, 32'h1234_5678, 32'h0000_0100, 1'b1);
    apply("R2 imm lsl zero", ish(2'b00, 5'd0, 4'd1), 1'b0, 32'h8765_4321, 32'h0, 1'b1);
    apply("R3 lsl by 32", rsh(2'b00, 4'd2, 4'd1), 1'b0, 32'h0000_0001, 32'd32, 1'b0);
    apply("R3 lsl by 33", rsh(2'b00, 4'd2, 4'd1), 1'b0, 32'hFFFF_FFFF, 32'd33, 1'b1);
    apply("R4 lsr by 32", rsh(2'b01, 4'd2, 4'd1), 1'b0, 32'h8000_0000, 32'd32, 1'b0);
    apply("R4 lsr by 200", rsh(2'b01, 4'd2, 4'd1), 1'b0, 32'hFFFF_FFFF, 32'd200, 1'b1);
    apply("R4 imm lsr zero", ish(2'b01, 5'd0, 4'd1), 1'b0, 32'h8000_0001, 32'h0, 1'b0);
    apply("R5 asr by 40 neg", rsh(2'b10, 4'd2, 4'd1), 1'b0, 32'h8000_0000, 32'd40, 1'b0);
    apply("R5 asr by 255 pos", rsh(2'b10, 4'd2, 4'd1), 1'b0, 32'h7FFF_FFFF, 32'd255, 1'b1);
    apply("R5 imm asr zero", ish(2'b10, 5'd0, 4'd1), 1'b0, 32'h9000_0000, 32'h0, 1'b0);
    apply("R6 ror by 64", rsh(2'b11, 4'd2, 4'd1), 1'b0, 32'h8000_0001, 32'd64, 1'b0);
    apply("R6 ror by 32 pos", rsh(2'b11, 4'd2, 4'd1), 1'b0, 32'h7000_0001, 32'd32, 1'b1);
    apply("R6 rrx", ish(2'b11, 5'd0, 4'd1), 1'b0, 32'h0000_0003, 32'h0, 1'b1);
    apply("R7 lsl 1", ish(2'b00, 5'd1, 4'd1), 1'b0, 32'h8000_0000, 32'h0, 1'b0);
    apply("R7 lsr 31", ish(2'b01, 5'd31, 4'd1), 1'b0, 32'h4000_0000, 32'h0, 1'b0);
    apply("R7 ror reg 8", rsh(2'b11, 4'd2, 4'd1), 1'b0, 32'h0000_00FF, 32'd8, 1'b0);
    apply("R7 ror reg 40", rsh(2'b11, 4'd2, 4'd1), 1'b0, 32'h0000_0180, 32'd40, 1'b0);
    apply("R7 asr 4", ish(2'b10, 5'd4, 4'd1), 1'b0, 32'hF000_0008, 32'h0, 1'b0);
    apply("R8 no rotation", cst(4'd0, 8'h80), 1'b1, 32'h0, 32'h0, 1'b1);
    apply("R8 rotate 2 low", cst(4'd1, 8'h01), 1'b1, 32'h0, 32'h0, 1'b1);
    apply("R8 rotate 2 high", cst(4'd1, 8'h02), 1'b1, 32'h0, 32'h0, 1'b0);
    apply("R8 rotate 30", cst(4'd15, 8'hC1), 1'b1, 32'h0, 32'h0, 1'b0);
    apply("R9 const with bit4", cst(4'd0, 8'h10), 1'b1, 32'h5, 32'h5, 1'b0);
    apply("R9 reg shift", rsh(2'b00, 4'd3, 4'd2), 1'b0, 32'h5, 32'd1, 1'b0);
    apply("R10 rm is pc", rsh(2'b00, 4'd2, 4'd15), 1'b0, 32'h0000_0100, 32'd0, 1'b0);
    apply("R10 rs is pc", rsh(2'b00, 4'd15, 4'd1), 1'b0, 32'h0000_0001, 32'd28, 1'b0);
    apply("R10 imm form no offset", ish(2'b00, 5'd0, 4'd15), 1'b0, 32'h0000_0100, 32'd0, 1'b0);
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ins;
      logic [31:0] b;
      ins = $urandom;
      b = $urandom;
      if (i % 3 == 0) b = {24'h0, 8'($urandom_range(0, 70))};
      apply("R1 random", ins, 1'($urandom), $urandom, b, 1'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule